// File: doc/BRIEF.md
# March C- Memory Self-Test Controller

This block drives a single-port synchronous RAM through the six-pass March C- sequence and reports whether every read returned the expected background. One address counter serves all passes and counts up or down. One comparator checks every read. A "0" background is an all-zeros data word and a "1" background is an all-ones word.

A pulse on `start_i` launches a run. `busy_o` stays high for the whole run. `done_o` then stays high until the next start. The first mismatch sets a sticky fail flag and records the pass number and the address. The run still goes on to its end.

A fault-injection mask, loaded through `inj_we_i`, inverts the chosen data bits on every write. This lets the test be checked against a fault known in advance. Status leaves the block through a serial scan port.

Top module: `mbist_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `done_o`, `mem_we_o`, `mem_re_o` and `scan_o` are 0.
- R2: A `start_i` pulse while idle or done begins a run in the next cycle. A `start_i` pulse during a run is ignored: the operation sequence and the run length are unchanged.
- R3: A run issues one memory operation per cycle and never reads and writes in the same cycle. The passes, numbered 1 to 6, are: 1 writes 0 ascending; 2 reads 0 then writes 1 at each address, ascending; 3 reads 1 then writes 0, ascending; 4 reads 0 then writes 1, descending; 5 reads 1 then writes 0, descending; 6 reads 0, ascending. `mem_wdata_o` is 0 in cycles without a write.
- R4: `busy_o` is high for exactly 10·2^ADDR_W + 1 cycles. `done_o` then rises and holds with no memory activity until the next start.
- R5: Read data is compared with the all-zeros or all-ones background in the cycle after the read is issued. A mismatch sets the fail flag.
- R6: Only the first mismatch of a run records its pass number (1..6) and address. Later mismatches change neither, and the run still completes all six passes.
- R7: Pulsing `inj_we_i` loads `inj_mask_i` into the injection mask. Every write then drives background XOR mask. A nonzero mask makes a run fail in pass 2 at address 0.
- R8: While `scan_en_i` is low, the scan register loads {fail, pass[2:0], address[ADDR_W-1:0]}, with fail in the MSB. `scan_clk_en_i` has no effect then. While `scan_en_i` is high, each cycle with `scan_clk_en_i` shifts the register left with zero fill. `scan_o` is always the MSB.
- R9: Each start clears the fail flag and the recorded pass and address.
- R10: A run on a fault-free memory with a zero mask ends with fail, pass and address all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request pulse |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until next start |
| inj_we_i | input | 1 | Load strobe for injection mask |
| inj_mask_i | input | DATA_W | Bits to invert on writes |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_we_o | output | 1 | RAM write enable |
| mem_re_o | output | 1 | RAM read enable |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after read |
| scan_en_i | input | 1 | Scan shift mode |
| scan_clk_en_i | input | 1 | Scan shift strobe |
| scan_o | output | 1 | Scan serial output |

## Verification
In passes 2 to 5, the comparison of an address's read falls in the same cycle as the write to that same address. The comparison must use the data the RAM registered a cycle earlier and not the word being written. A memory model in the bench holds stuck bits at chosen addresses, and single and double faults are placed where they first show in pass 2 or pass 3. The scanned pass and address must name exactly the first faulty read. A nonzero injection mask provokes the same overlap from the write side.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int ELEM_W = 3;
  localparam logic [ELEM_W-1:0] FIRST_ELEM = 3'd1;
  localparam logic [ELEM_W-1:0] LAST_ELEM  = 3'd6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic rd;    // element contains a read
    logic wr;    // element contains a write
    logic rbg;   // expected read background
    logic wbg;   // written background
    logic down;  // descending address order
  } elem_t;

  function automatic elem_t elem_info(logic [ELEM_W-1:0] e);
    elem_t r;
    r = '0;
    case (e)
      3'd1: r = '{rd: 1'b0, wr: 1'b1, rbg: 1'b0, wbg: 1'b0, down: 1'b0};
      3'd2: r = '{rd: 1'b1, wr: 1'b1, rbg: 1'b0, wbg: 1'b1, down: 1'b0};
      3'd3: r = '{rd: 1'b1, wr: 1'b1, rbg: 1'b1, wbg: 1'b0, down: 1'b0};
      3'd4: r = '{rd: 1'b1, wr: 1'b1, rbg: 1'b0, wbg: 1'b1, down: 1'b1};
      3'd5: r = '{rd: 1'b1, wr: 1'b1, rbg: 1'b1, wbg: 1'b0, down: 1'b1};
      3'd6: r = '{rd: 1'b1, wr: 1'b0, rbg: 1'b0, wbg: 1'b0, down: 1'b0};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic elem_is_down(logic [ELEM_W-1:0] e);
    return (e == 3'd4) || (e == 3'd5);
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              load_down_i,
  input  logic              step_i,
  input  logic              down_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= load_down_i ? ADDR_TOP : '0;
    end else if (step_i) begin
      addr_q <= down_i ? addr_q - 1'b1 : addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = down_i ? (addr_q == '0) : (addr_q == ADDR_TOP);

  // the controller must switch elements instead of wrapping the counter
  a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o);

  a_r3_load_step_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ELEM_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              issue_i,
  input  logic              exp_bg_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [ADDR_W-1:0] fail_addr_o
);

  logic              pend_q;
  logic              bg_q;
  logic [ELEM_W-1:0] elem_p_q;
  logic [ADDR_W-1:0] addr_p_q;
  logic              fail_q;
  logic [ELEM_W-1:0] fail_elem_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic              mismatch;

  // read issued last cycle: capture its context, data arrives now
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      bg_q     <= 1'b0;
      elem_p_q <= '0;
      addr_p_q <= '0;
    end else begin
      pend_q   <= issue_i;
      bg_q     <= exp_bg_i;
      elem_p_q <= elem_i;
      addr_p_q <= addr_i;
    end
  end

  assign mismatch = pend_q && (rdata_i != {DATA_W{bg_q}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      fail_elem_q <= '0;
      fail_addr_q <= '0;
    end else if (clr_i) begin
      fail_q      <= 1'b0;
      fail_elem_q <= '0;
      fail_addr_q <= '0;
    end else if (mismatch && !fail_q) begin
      fail_q      <= 1'b1;
      fail_elem_q <= elem_p_q;
      fail_addr_q <= addr_p_q;
    end
  end

  assign fail_o      = fail_q;
  assign fail_elem_o = fail_elem_q;
  assign fail_addr_o = fail_addr_q;

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !clr_i) |=> (fail_q && $stable(fail_elem_q) && $stable(fail_addr_q)));

  a_r6_elem_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |-> (fail_elem_q != '0));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fail_q);

endmodule

// File: rtl/mbist_scan.sv
module mbist_scan #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         shift_i,
  input  logic [W-1:0] par_i,
  output logic         so_o
);

  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (!en_i) begin
      sh_q <= par_i;
    end else if (shift_i) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign so_o = sh_q[W-1];

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !shift_i) |=> $stable(so_o));

  a_r8_shift_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && shift_i) |=> (so_o == $past(sh_q[W-2])));

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              inj_we_i,
  input  logic [DATA_W-1:0] inj_mask_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              scan_en_i,
  input  logic              scan_clk_en_i,
  output logic              scan_o
);

  localparam int SCAN_W = 1 + ELEM_W + ADDR_W;

  state_e            state_q, state_d;
  logic [ELEM_W-1:0] elem_q, elem_d, elem_nx;
  logic              phase_q, phase_d;
  logic [DATA_W-1:0] mask_q;
  elem_t             cur;

  logic              ag_load, ag_load_down, ag_step, ag_last;
  logic [ADDR_W-1:0] addr;
  logic              op_rd, op_wr, both, adv, clr;
  logic              fail;
  logic [ELEM_W-1:0] fail_elem;
  logic [ADDR_W-1:0] fail_addr;

  assign cur     = elem_info(elem_q);
  assign elem_nx = elem_q + 1'b1;
  assign both    = cur.rd && cur.wr;

  always_comb begin
    state_d      = state_q;
    elem_d       = elem_q;
    phase_d      = phase_q;
    ag_load      = 1'b0;
    ag_load_down = 1'b0;
    ag_step      = 1'b0;
    clr          = 1'b0;
    op_rd        = 1'b0;
    op_wr        = 1'b0;
    adv          = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_RUN;
          elem_d  = FIRST_ELEM;
          phase_d = 1'b0;
          ag_load = 1'b1;
          clr     = 1'b1;
        end
      end
      ST_RUN: begin
        op_rd = cur.rd && !phase_q;
        op_wr = cur.wr && (phase_q || !cur.rd);
        adv   = both ? phase_q : 1'b1;
        if (both) phase_d = !phase_q;
        if (adv) begin
          if (ag_last) begin
            if (elem_q == LAST_ELEM) begin
              state_d = ST_DRAIN;
            end else begin
              elem_d       = elem_nx;
              ag_load      = 1'b1;
              ag_load_down = elem_is_down(elem_nx);
            end
          end else begin
            ag_step = 1'b1;
          end
        end
      end
      ST_DRAIN: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (inj_we_i) mask_q <= inj_mask_i;
  end

  mbist_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ag_load),
    .load_down_i (ag_load_down),
    .step_i      (ag_step),
    .down_i      (cur.down),
    .addr_o      (addr),
    .last_o      (ag_last)
  );

  mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ELEM_W(ELEM_W)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .issue_i     (op_rd),
    .exp_bg_i    (cur.rbg),
    .elem_i      (elem_q),
    .addr_i      (addr),
    .rdata_i     (mem_rdata_i),
    .fail_o      (fail),
    .fail_elem_o (fail_elem),
    .fail_addr_o (fail_addr)
  );

  mbist_scan #(.W(SCAN_W)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (scan_en_i),
    .shift_i (scan_clk_en_i),
    .par_i   ({fail, fail_elem, fail_addr}),
    .so_o    (scan_o)
  );

  assign mem_addr_o  = addr;
  assign mem_we_o    = op_wr;
  assign mem_re_o    = op_rd;
  assign mem_wdata_o = op_wr ? ({DATA_W{cur.wbg}} ^ mask_q) : '0;
  assign busy_o      = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign done_o      = (state_q == ST_DONE);

  a_r3_one_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  a_r4_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_we_o && !mem_re_o && !busy_o));

  a_r2_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && start_i) |=> busy_o);

  a_r4_done_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == ST_DRAIN));

endmodule

// File: tb/mbist_ctrl_test.sv
module mbist_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int N    = 1 << AW;
  localparam int NOPS = 10 * N;
  localparam int SW   = 1 + 3 + AW;
  localparam int NV   = 8;

  // columns: mask, f1 en/addr/bit/val, f2 en/addr/bit/val, exp fail/elem/addr
  localparam int VEC [NV][12] = '{
    '{  0, 0,  0, 0, 0, 0, 0, 0, 0, 0, 0,  0},
    '{  1, 0,  0, 0, 0, 0, 0, 0, 0, 1, 2,  0},
    '{  0, 1,  5, 0, 1, 0, 0, 0, 0, 1, 2,  5},
    '{  0, 1,  3, 2, 0, 0, 0, 0, 0, 1, 3,  3},
    '{  0, 1, 15, 7, 0, 0, 0, 0, 0, 1, 3, 15},
    '{  0, 1,  9, 3, 1, 1, 2, 4, 1, 1, 2,  2},
    '{  0, 1,  0, 0, 0, 0, 0, 0, 0, 1, 3,  0},
    '{  0, 0,  0, 0, 0, 0, 0, 0, 0, 0, 0,  0}
  };

  // element table: read, write, read bg, write bg, descending
  localparam bit E_RD [6] = '{0, 1, 1, 1, 1, 1};
  localparam bit E_WR [6] = '{1, 1, 1, 1, 1, 0};
  localparam bit E_WB [6] = '{0, 1, 0, 1, 0, 0};
  localparam bit E_DN [6] = '{0, 0, 0, 1, 1, 0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done;
  logic          inj_we = 1'b0;
  logic [DW-1:0] inj_mask = '0;
  logic [AW-1:0] maddr;
  logic [DW-1:0] wdata, rdata;
  logic          we, re;
  logic          scan_en = 1'b0, scan_ce = 1'b0;
  logic          scan_out;

  int checks = 0;
  int errors = 0;

  mbist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .busy_o        (busy),
    .done_o        (done),
    .inj_we_i      (inj_we),
    .inj_mask_i    (inj_mask),
    .mem_addr_o    (maddr),
    .mem_wdata_o   (wdata),
    .mem_we_o      (we),
    .mem_re_o      (re),
    .mem_rdata_i   (rdata),
    .scan_en_i     (scan_en),
    .scan_clk_en_i (scan_ce),
    .scan_o        (scan_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // RAM model with stuck bits applied on read
  logic [DW-1:0] mem [N];
  bit f1_en, f1_v, f2_en, f2_v;
  int f1_a, f1_b, f2_a, f2_b;

  function automatic logic [DW-1:0] faulty(int a, logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = d;
    if (f1_en && a == f1_a) r[f1_b] = f1_v;
    if (f2_en && a == f2_a) r[f2_b] = f2_v;
    return r;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) mem[i] = 8'hA5;
    rdata = '0;
  end

  always @(posedge clk) begin
    if (re) rdata <= faulty(int'(maddr), mem[maddr]);
    if (we) mem[maddr] <= wdata;
  end

  // expected operation stream
  bit            x_we [NOPS];
  bit            x_re [NOPS];
  logic [AW-1:0] x_ad [NOPS];
  logic [DW-1:0] x_wd [NOPS];
  int op_idx, busy_cnt, seq_bad;

  task automatic build(input logic [DW-1:0] m);
    int k = 0;
    for (int e = 0; e < 6; e++) begin
      for (int j = 0; j < N; j++) begin
        int a = E_DN[e] ? N - 1 - j : j;
        if (E_RD[e]) begin
          x_we[k] = 0; x_re[k] = 1; x_ad[k] = AW'(a); x_wd[k] = '0; k++;
        end
        if (E_WR[e]) begin
          x_we[k] = 1; x_re[k] = 0; x_ad[k] = AW'(a);
          x_wd[k] = {DW{E_WB[e]}} ^ m; k++;
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (we || re) begin
      if (op_idx >= NOPS || we != x_we[op_idx] || re != x_re[op_idx] ||
          maddr != x_ad[op_idx] || wdata != x_wd[op_idx])
        seq_bad++;
      op_idx++;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic scan_read(output logic [SW-1:0] w);
    w = '0;
    @(negedge clk) scan_en = 1'b1;
    for (int i = 0; i < SW; i++) begin
      w = {w[SW-2:0], scan_out};
      scan_ce = 1'b1;
      @(negedge clk) scan_ce = 1'b0;
    end
    scan_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_vec(input int v, input bit poke);
    logic [SW-1:0] w, xw;
    logic [DW-1:0] m;
    string req;
    int n;
    m = DW'(VEC[v][0]);
    f1_en = VEC[v][1] != 0; f1_a = VEC[v][2]; f1_b = VEC[v][3]; f1_v = VEC[v][4] != 0;
    f2_en = VEC[v][5] != 0; f2_a = VEC[v][6]; f2_b = VEC[v][7]; f2_v = VEC[v][8] != 0;
    @(negedge clk) begin inj_we = 1'b1; inj_mask = m; end
    @(negedge clk) inj_we = 1'b0;
    build(m);
    op_idx = 0; busy_cnt = 0; seq_bad = 0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      start = poke && (n == 40);
    end
    start = 1'b0;
    chk("R2 run reaches done", done, int'(done), 1);
    chk(poke ? "R2 busy length with start mid-run" : "R4 busy length",
        busy_cnt == NOPS + 1, busy_cnt, NOPS + 1);
    chk(poke ? "R2 sequence with start mid-run" : "R3 operation sequence",
        seq_bad == 0 && op_idx == NOPS, seq_bad, 0);
    repeat (3) @(negedge clk);
    chk("R4 done held", done && !busy && !we && !re, int'(done), 1);
    scan_read(w);
    xw = {VEC[v][9] != 0, 3'(VEC[v][10]), AW'(VEC[v][11])};
    if (v == 0)       req = "R10 clean status";
    else if (v == 1)  req = "R7 injected mask";
    else if (v == 5)  req = "R6 first of two faults";
    else if (v == 7)  req = "R9 status cleared by start";
    else              req = "R5 fault capture";
    chk(req, w == xw, int'(w), int'(xw));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [SW-1:0] w0, w1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", !busy && !done && !we && !re && !scan_out, int'({busy, done, we, re}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", !busy && !done && !we && !re && !scan_out, int'({busy, done, we, re}), 0);

    for (int v = 0; v < NV; v++) run_vec(v, v == 3);

    // failing run, then scan strobes with scan_en low must not disturb status
    run_vec(2, 1'b0);
    scan_read(w0);
    repeat (3) begin
      @(negedge clk) scan_ce = 1'b1;
    end
    @(negedge clk) scan_ce = 1'b0;
    scan_read(w1);
    chk("R8 strobe ignored without scan_en", w1 == w0, int'(w1), int'(w0));

    // scan_en high without strobe holds the MSB
    @(negedge clk) scan_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 hold without strobe", scan_out == w0[SW-1], int'(scan_out), int'(w0[SW-1]));
    scan_en = 1'b0;
    @(negedge clk);

    // mask load in done state: status unchanged until a new start
    @(negedge clk) begin inj_we = 1'b1; inj_mask = 8'hFF; end
    @(negedge clk) inj_we = 1'b0;
    repeat (2) @(negedge clk);
    scan_read(w1);
    chk("R7 mask load leaves status", w1 == w0 && done, int'(w1), int'(w0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule